// File: doc/BRIEF.md
# Channel Migration Message Redirector

This block sits in the message path of one logical channel between tasks on a network on chip. It lets the receiving task move from one tile to another while the sender keeps transmitting. Every message comes in on a valid/ready input and leaves on a valid/ready output. The output carries the same payload and channel tag, plus the tile address the network should deliver it to.

Software moves the channel through a migration using three single-cycle command pulses: begin, switchover and finish. The phases are a preparation phase, a switchover phase and a drain phase. The handover mode and the two tile addresses are captured when migration begins. In dual-send mode each message is copied to both tiles. In forward mode each message arriving at the old location is sent on to the new tile. In the drain phase, duplication continues for a programmed number of messages. After that, traffic goes only to the new tile and the block returns to its resting phase. The switchover command is the only point tied to the movement of the task itself. The sender sees no difference between phases.

Top module: `mig_chan_redirector`

## Requirements
- R1: The `phase_o` output encodes rest=0, prepare=1, switchover=2, drain=3. A `cmd_begin` pulse in rest, a `cmd_switch` pulse in prepare and a `cmd_finish` pulse in switchover each move the phase to the next value at the following clock edge. The phase never changes in any other way, except for the automatic return of R7.
- R2: Traffic is never halted. `out_valid` equals `in_valid` in every cycle. Whenever a message needs only one copy, `in_ready` equals `out_ready`.
- R3: In rest, each message is emitted exactly once, addressed to the current value of `cfg_home_tile`.
- R4: In dual-send mode (`cfg_fwd_mode`=0) during migration, each message is emitted twice: first to the home tile captured at the begin command, then to the target tile captured at the same command. `in_ready` stays low until the second copy is taken. Changing `cfg_home_tile` or `cfg_target_tile` after the begin command has no effect until the next begin.
- R5: In forward mode (`cfg_fwd_mode`=1) during migration, each message is emitted once, addressed to the captured target tile.
- R6: A command pulse that does not match the current phase is ignored (the phase is unchanged). It sets `seq_err`, which stays set until reset.
- R7: In the drain phase, the first N accepted messages are handled as in R4 or R5, where N is `cfg_drain` captured at the begin command. Any later message goes once to the target tile. One clock edge after the N-th message has been accepted (one edge after entering drain when N=0), the phase returns to rest.
- R8: Each copy carries `in_data` and `in_chan` unchanged. Per destination tile, messages leave in their arrival order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Incoming message valid |
| in_ready | output | 1 | Incoming message accepted when high with in_valid |
| in_data | input | PAYLOAD_W | Message payload |
| in_chan | input | CHAN_W | Channel tag |
| out_valid | output | 1 | Outgoing copy valid |
| out_ready | input | 1 | Network takes the copy |
| out_data | output | PAYLOAD_W | Payload of the copy |
| out_chan | output | CHAN_W | Channel tag of the copy |
| out_tile | output | TILE_W | Destination tile of the copy |
| cfg_home_tile | input | TILE_W | Current (old) destination tile |
| cfg_target_tile | input | TILE_W | New destination tile |
| cfg_fwd_mode | input | 1 | 1 = forward, 0 = dual-send |
| cfg_drain | input | DRAIN_W | Messages still duplicated in the drain phase |
| cmd_begin | input | 1 | Pulse: start migration |
| cmd_switch | input | 1 | Pulse: switchover |
| cmd_finish | input | 1 | Pulse: enter drain |
| phase_o | output | 2 | Current phase (R1 encoding) |
| seq_err | output | 1 | Sticky out-of-order command flag |

## Verification
Messages are sent in rest, in both handover modes across all three phases, and in the drained part of the drain phase. Random stalls on `out_ready` separate held-input dual-send from single-copy pass-through, and show whether a copy is lost or repeated. The tile configuration is changed in the middle of a migration, which shows whether the addresses were captured or are still live. Drain counts of zero and above, together with misordered and overlapping command pulses, exercise the automatic return to rest and the sticky error.

// File: rtl/mig_redir_pkg.sv
package mig_redir_pkg;
  typedef enum logic [1:0] {
    PH_REST   = 2'd0,
    PH_PREP   = 2'd1,
    PH_SWITCH = 2'd2,
    PH_DRAIN  = 2'd3
  } mig_phase_e;
endpackage

// File: rtl/mig_phase_ctrl.sv
module mig_phase_ctrl
  import mig_redir_pkg::*;
#(
  parameter int TILE_W  = 6,
  parameter int DRAIN_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmd_begin,
  input  logic               cmd_switch,
  input  logic               cmd_finish,
  input  logic [TILE_W-1:0]  cfg_home_tile,
  input  logic [TILE_W-1:0]  cfg_target_tile,
  input  logic               cfg_fwd_mode,
  input  logic [DRAIN_W-1:0] cfg_drain,
  input  logic               msg_acc,
  output mig_phase_e         phase,
  output logic               seq_err,
  output logic [TILE_W-1:0]  home_cap,
  output logic [TILE_W-1:0]  target_cap,
  output logic               redirect,
  output logic               dual_en
);
  localparam logic [DRAIN_W-1:0] CNT_ONE = DRAIN_W'(1);

  mig_phase_e         phase_q, phase_d;
  logic               err_q, err_d, bad_cmd;
  logic [DRAIN_W-1:0] cnt_q, cnt_d, drain_q;
  logic [TILE_W-1:0]  home_q, target_q;
  logic               fwd_q, cap_en, cnt_en;

  // next-state logic
  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    cap_en  = 1'b0;
    bad_cmd = 1'b0;
    unique case (phase_q)
      PH_REST: begin
        bad_cmd = cmd_switch | cmd_finish;
        if (cmd_begin) begin
          phase_d = PH_PREP;
          cap_en  = 1'b1;
        end
      end
      PH_PREP: begin
        bad_cmd = cmd_begin | cmd_finish;
        if (cmd_switch) phase_d = PH_SWITCH;
      end
      PH_SWITCH: begin
        bad_cmd = cmd_begin | cmd_switch;
        if (cmd_finish) begin
          phase_d = PH_DRAIN;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      end
      PH_DRAIN: begin
        bad_cmd = cmd_begin | cmd_switch | cmd_finish;
        if (cnt_q >= drain_q) begin
          phase_d = PH_REST;
        end else if (msg_acc) begin
          cnt_d  = cnt_q + CNT_ONE;
          cnt_en = 1'b1;
        end
      end
      default: phase_d = PH_REST;
    endcase
    err_d = err_q | bad_cmd;
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_REST;
      err_q   <= 1'b0;
    end else begin
      phase_q <= phase_d;
      err_q   <= err_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  // configuration captured at the begin command
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      home_q   <= '0;
      target_q <= '0;
      fwd_q    <= 1'b0;
      drain_q  <= '0;
    end else if (cap_en) begin
      home_q   <= cfg_home_tile;
      target_q <= cfg_target_tile;
      fwd_q    <= cfg_fwd_mode;
      drain_q  <= cfg_drain;
    end
  end

  assign phase      = phase_q;
  assign seq_err    = err_q;
  assign home_cap   = home_q;
  assign target_cap = target_q;
  assign redirect   = (phase_q != PH_REST);
  assign dual_en    = !fwd_q &&
                      ((phase_q == PH_PREP) || (phase_q == PH_SWITCH) ||
                       ((phase_q == PH_DRAIN) && (cnt_q < drain_q)));
endmodule

// File: rtl/mig_copy_steer.sv
module mig_copy_steer #(
  parameter int TILE_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              out_ready,
  input  logic              redirect,
  input  logic              dual_en,
  input  logic [TILE_W-1:0] live_home,
  input  logic [TILE_W-1:0] home_cap,
  input  logic [TILE_W-1:0] target_cap,
  output logic              in_ready,
  output logic              out_valid,
  output logic [TILE_W-1:0] out_tile,
  output logic              msg_acc
);
  logic second_q, second_d, fire;

  // copy selection: second copy of a dual message always targets the new tile
  always_comb begin
    if (second_q) begin
      out_tile = target_cap;
      in_ready = out_ready;
    end else if (dual_en) begin
      out_tile = home_cap;
      in_ready = 1'b0;
    end else begin
      out_tile = redirect ? target_cap : live_home;
      in_ready = out_ready;
    end
  end

  assign out_valid = in_valid;
  assign fire      = in_valid && out_ready;
  assign msg_acc   = in_valid && in_ready;

  always_comb begin
    second_d = second_q;
    if (fire) second_d = !second_q && dual_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
    end else if (fire) begin
      second_q <= second_d;
    end
  end
endmodule

// File: rtl/mig_chan_redirector.sv
module mig_chan_redirector
  import mig_redir_pkg::*;
#(
  parameter int PAYLOAD_W = 16,
  parameter int CHAN_W    = 4,
  parameter int TILE_W    = 6,
  parameter int DRAIN_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  output logic                 in_ready,
  input  logic [PAYLOAD_W-1:0] in_data,
  input  logic [CHAN_W-1:0]    in_chan,
  output logic                 out_valid,
  input  logic                 out_ready,
  output logic [PAYLOAD_W-1:0] out_data,
  output logic [CHAN_W-1:0]    out_chan,
  output logic [TILE_W-1:0]    out_tile,
  input  logic [TILE_W-1:0]    cfg_home_tile,
  input  logic [TILE_W-1:0]    cfg_target_tile,
  input  logic                 cfg_fwd_mode,
  input  logic [DRAIN_W-1:0]   cfg_drain,
  input  logic                 cmd_begin,
  input  logic                 cmd_switch,
  input  logic                 cmd_finish,
  output logic [1:0]           phase_o,
  output logic                 seq_err
);
  mig_phase_e        phase;
  logic [TILE_W-1:0] home_cap, target_cap;
  logic              redirect, dual_en, msg_acc;

  mig_phase_ctrl #(.TILE_W(TILE_W), .DRAIN_W(DRAIN_W)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .cmd_begin       (cmd_begin),
    .cmd_switch      (cmd_switch),
    .cmd_finish      (cmd_finish),
    .cfg_home_tile   (cfg_home_tile),
    .cfg_target_tile (cfg_target_tile),
    .cfg_fwd_mode    (cfg_fwd_mode),
    .cfg_drain       (cfg_drain),
    .msg_acc         (msg_acc),
    .phase           (phase),
    .seq_err         (seq_err),
    .home_cap        (home_cap),
    .target_cap      (target_cap),
    .redirect        (redirect),
    .dual_en         (dual_en)
  );

  mig_copy_steer #(.TILE_W(TILE_W)) u_steer (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .out_ready  (out_ready),
    .redirect   (redirect),
    .dual_en    (dual_en),
    .live_home  (cfg_home_tile),
    .home_cap   (home_cap),
    .target_cap (target_cap),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_tile   (out_tile),
    .msg_acc    (msg_acc)
  );

  assign out_data = in_data;
  assign out_chan = in_chan;
  assign phase_o  = phase;
endmodule

// File: rtl/mig_chan_redirector_chk.sv
module mig_chan_redirector_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       out_valid,
  input logic       out_ready,
  input logic       cmd_begin,
  input logic       cmd_switch,
  input logic       cmd_finish,
  input logic [1:0] phase_o,
  input logic       seq_err
);
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o != $past(phase_o)) |-> (phase_o == $past(phase_o) + 2'd1)); // R1
  AST_VALID_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |-> out_valid); // R2
  AST_REST_READY: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_o == 2'd0) |-> (in_ready == out_ready)); // R2
  AST_SECOND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_ready) |=> (in_ready == out_ready)); // R4
  AST_BAD_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase_o == 2'd0) && !cmd_begin && (cmd_switch || cmd_finish)) |=> (phase_o == 2'd0)); // R6
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    seq_err |=> seq_err); // R6
endmodule

bind mig_chan_redirector mig_chan_redirector_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .cmd_begin  (cmd_begin),
  .cmd_switch (cmd_switch),
  .cmd_finish (cmd_finish),
  .phase_o    (phase_o),
  .seq_err    (seq_err)
);

// File: tb/mig_chan_redirector_bench.sv
`timescale 1ns/1ps
module mig_chan_redirector_bench;
  localparam int PW = 16;
  localparam int CW = 4;
  localparam int TW = 6;
  localparam int DW = 4;

  logic clk, rst_n;
  logic in_valid, in_ready, out_valid, out_ready;
  logic [PW-1:0] in_data, out_data;
  logic [CW-1:0] in_chan, out_chan;
  logic [TW-1:0] out_tile, cfg_home_tile, cfg_target_tile;
  logic cfg_fwd_mode;
  logic [DW-1:0] cfg_drain;
  logic cmd_begin, cmd_switch, cmd_finish;
  logic [1:0] phase_o;
  logic seq_err;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // bench reference state
  int ph_m, cnt_m, drain_m;
  bit err_m, fwd_m;
  logic [TW-1:0] home_m, target_m;

  mig_chan_redirector #(.PAYLOAD_W(PW), .CHAN_W(CW), .TILE_W(TW), .DRAIN_W(DW)) u_mig_chan_redirector (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_chan(in_chan),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_chan(out_chan),
    .out_tile(out_tile),
    .cfg_home_tile(cfg_home_tile), .cfg_target_tile(cfg_target_tile),
    .cfg_fwd_mode(cfg_fwd_mode), .cfg_drain(cfg_drain),
    .cmd_begin(cmd_begin), .cmd_switch(cmd_switch), .cmd_finish(cmd_finish),
    .phase_o(phase_o), .seq_err(seq_err)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic string copy_req();
    if (ph_m == 0) return "R3";
    if (fwd_m) return "R5";
    if (ph_m == 3 && cnt_m >= drain_m) return "R7";
    return "R4";
  endfunction

  task automatic check_state(input string req);
    @(negedge clk); #1;
    chk(int'(phase_o) == ph_m, req, "phase", int'(phase_o), ph_m);
    chk(seq_err == err_m, "R6", "seq_err", int'(seq_err), int'(err_m));
  endtask

  // k: 1 begin, 2 switch, 3 finish
  task automatic cmd(input int k);
    @(negedge clk);
    cmd_begin  = (k == 1);
    cmd_switch = (k == 2);
    cmd_finish = (k == 3);
    @(posedge clk);
    if (ph_m < 3 && k == ph_m + 1) begin
      ph_m = k;
      if (k == 1) begin
        home_m = cfg_home_tile; target_m = cfg_target_tile;
        fwd_m = cfg_fwd_mode; drain_m = int'(cfg_drain);
      end
      if (k == 3) cnt_m = 0;
    end else begin
      err_m = 1'b1;
    end
    @(negedge clk);
    cmd_begin = 1'b0; cmd_switch = 1'b0; cmd_finish = 1'b0;
    @(posedge clk);
    if (ph_m == 3 && cnt_m >= drain_m) ph_m = 0;  // automatic return (R7)
    check_state("R1");
  endtask

  task automatic send_msg();
    logic [PW-1:0] d;
    logic [CW-1:0] c;
    logic [TW-1:0] e0, e1;
    logic [TW-1:0] got [4];
    int ne, n, guard;
    bit acc;
    string rq;
    d = PW'($urandom); c = CW'($urandom);
    rq = copy_req();
    if (ph_m == 0) begin ne = 1; e0 = cfg_home_tile; e1 = '0; end
    else if (fwd_m || (ph_m == 3 && cnt_m >= drain_m)) begin ne = 1; e0 = target_m; e1 = '0; end
    else begin ne = 2; e0 = home_m; e1 = target_m; end
    for (int i = 0; i < 4; i++) got[i] = '0;
    @(negedge clk);
    in_valid = 1'b1; in_data = d; in_chan = c;
    n = 0; acc = 1'b0; guard = 0;
    while (!acc && guard < 200) begin
      out_ready = (($urandom % 4) != 0);
      #1;
      chk(out_valid == 1'b1, "R2", "out_valid", int'(out_valid), 1);
      if (ne == 1) chk(in_ready == out_ready, "R2", "in_ready", int'(in_ready), int'(out_ready));
      if (out_ready) begin
        if (n < 4) got[n] = out_tile;
        n++;
        chk(out_data == d && out_chan == c, "R8", "payload", int'(out_data), int'(d));
        acc = in_ready;
      end
      @(posedge clk);
      if (!acc) @(negedge clk);
      guard++;
    end
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b0;
    chk(n == ne, rq, "copy count", n, ne);
    chk(got[0] == e0, rq, "first tile", int'(got[0]), int'(e0));
    if (ne == 2) chk(got[1] == e1, rq, "second tile", int'(got[1]), int'(e1));
    if (ph_m == 3) begin
      cnt_m++;
      if (cnt_m >= drain_m) begin
        @(posedge clk);
        ph_m = 0;
        check_state("R7");
      end
    end
  endtask

  task automatic rand_cfg();
    cfg_home_tile   = TW'($urandom);
    cfg_target_tile = TW'($urandom);
    cfg_fwd_mode    = ($urandom % 2) == 1;
    cfg_drain       = DW'($urandom % 5);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1; in_data = '0; in_chan = '0;
    cmd_begin = 1'b0; cmd_switch = 1'b0; cmd_finish = 1'b0;
    cfg_home_tile = 6'd5; cfg_target_tile = 6'd9; cfg_fwd_mode = 1'b0; cfg_drain = 4'd2;
    ph_m = 0; cnt_m = 0; drain_m = 0; err_m = 0; fwd_m = 0; home_m = '0; target_m = '0;
    repeat (3) @(posedge clk);
    #1;
    chk(phase_o == 2'd0, "R1", "reset phase", int'(phase_o), 0);
    chk(seq_err == 1'b0, "R6", "reset err", int'(seq_err), 0);
    chk(out_valid == 1'b0, "R2", "reset out_valid", int'(out_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    // rest traffic (R3)
    repeat (3) send_msg();
    // dual-send migration, drain 2, tiles changed mid-way (R4, R7)
    cmd(1);
    cfg_home_tile = 6'd33; cfg_target_tile = 6'd44;
    repeat (2) send_msg();
    cmd(2); send_msg();
    cmd(3); repeat (3) send_msg();
    // forward migration, drain 1 (R5)
    cfg_home_tile = 6'd12; cfg_target_tile = 6'd20; cfg_fwd_mode = 1'b1; cfg_drain = 4'd1;
    cmd(1); send_msg(); cmd(2); send_msg(); cmd(3); repeat (2) send_msg();
    // drain zero: straight back to rest (R7)
    cfg_fwd_mode = 1'b0; cfg_drain = 4'd0;
    cmd(1); send_msg(); cmd(2); cmd(3); send_msg();
    // misordered commands (R6)
    cmd(2); cmd(3); cmd(1); cmd(1); cmd(3); cmd(2); cmd(2); cmd(3);
    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = int'($urandom % 10);
      if (op < 2 && ph_m == 0) rand_cfg();
      else if (op == 2) begin
        cfg_home_tile = TW'($urandom); cfg_target_tile = TW'($urandom);
      end
      if (op < 6) send_msg();
      else cmd(int'($urandom % 3) + 1);
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule